// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits at the front of an external memory controller and turns a bus address into a chip-select. It holds one mapping register per chip select. Each register carries a window base, a window-size mask and an enable bit. On every cycle the block compares the incoming bus address against every enabled window. It then drives a one-hot chip-select vector with the window size of the selected window. If no window matches, the vector is all zero.

The mapping registers are written and read through a simple 32-bit register port. Before a window is allowed to decode, the block checks that its base and mask form a legal pair. An enabled but illegal pair raises a per-chip-select error flag and never selects. A small event-status and enable register pair drives one level-sensitive interrupt. Chip select 0 comes out of reset already enabled at address zero, so a boot fetch can be served before software touches the block.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, the mapping register of chip select 0 reads 0x0000_0F40 (enabled, base 0, mask 0xF), those of chip selects 1 to 7 read 0x0000_0F00, event status and event enable read 0, and the interrupt is low.
- R2: The mapping register of chip select n sits at byte offset 0x078 + 0x30·n. Bits [5:0] are the base, bit 6 is the enable and bits [11:8] are the mask. All other bits read 0 whatever was written.
- R3: A mapping is legal only when the mask is 0x8, 0xC, 0xE or 0xF and every base bit [3:0] at a position where the mask is 0 is itself 0. `map_err[n]` is high exactly when chip select n is enabled with an illegal mapping, and such a chip select never selects.
- R4: An address selects chip select n when n is enabled and legal, address bits [31:30] are 0, and address bits [29:24] equal the base at every position where {2'b11, mask} is 1. `cs_hit_size` then equals 2^(24 + number of zero bits in the mask): 16 MiB for 0xF, 32 MiB for 0xE, 64 MiB for 0xC and 128 MiB for 0x8.
- R5: When several windows match, the lowest-numbered chip select wins. `cs_sel` has at most one bit set. With no match, `cs_sel` and `cs_hit_size` are 0.
- R6: A write to a mapping register changes the decode from the next cycle on. From then on the old window no longer selects and the new one does.
- R7: Event status (offset 0x018) keeps only bits under 0xF03. Each such bit is set by a high `evt_in` bit and cleared by writing a 1 to it, and a set in the same cycle wins over a clear. `evt_in` bits outside 0xF03 are ignored.
- R8: Event enable (offset 0x01C) is read/write and keeps only the bits under 0xF03.
- R9: `irq` is registered and equals, one clock later, the OR over all bits of event status AND event enable.
- R10: The identification register at 0x000 reads the parameter `ID_VALUE`, the reset-done register at 0x014 always reads 1, and writes to both have no effect. Reads of any offset not named here return 0.
- R11: A read request presents its data on `reg_rdata` after the next clock edge, and `reg_rdata` holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | Bus address to decode |
| cs_sel | output | 8 | One-hot chip select, zero when no window matches |
| cs_hit_size | output | 28 | Size in bytes of the selected window, zero on no match |
| map_err | output | 8 | Per chip select: enabled with an illegal mapping |
| evt_in | input | 12 | Interrupt event sources, one cycle high to set status |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted mapping register shows up on `cs_sel` and `cs_hit_size` in the same cycle that an address inside the affected window is presented. It also shows up on `map_err` at once, without any address traffic. A wrong decision in the priority chain or in the legality check appears only when an overlapping or illegal window is actually addressed, so the stimulus deliberately creates overlaps and illegal pairs. A fault in the status or enable register reaches `irq` one clock later. Any register fault is also visible on `reg_rdata` one clock after a read.

// File: rtl/cswd_pkg.sv
// Shared types, constants and helper functions for the chip-select window decoder.
// Assumes a fixed mapping-register layout: base [5:0], enable [6], mask [11:8].
package cswd_pkg;

    localparam int BASE_W = 6;
    localparam int MASK_W = 4;
    localparam int IRQ_W  = 12;
    localparam int SIZE_W = 28;

    localparam logic [IRQ_W-1:0] IRQ_KEEP = 12'hF03;

    // register offsets (byte addresses within a 4 KiB space)
    localparam logic [11:0] OFF_ID       = 12'h000;
    localparam logic [11:0] OFF_RSTDONE  = 12'h014;
    localparam logic [11:0] OFF_EVT_STAT = 12'h018;
    localparam logic [11:0] OFF_EVT_EN   = 12'h01C;
    localparam int          MAP_FIRST    = 32'h078;
    localparam int          MAP_STRIDE   = 32'h030;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } map_t;

    // Extract the writable mapping fields from a register word.
    function automatic map_t word_to_map(input logic [11:0] w);
        map_t m;
        m.mask  = w[11:8];
        m.valid = w[6];
        m.base  = w[5:0];
        return m;
    endfunction

    // Rebuild the register word from the stored mapping fields.
    function automatic logic [31:0] map_to_word(input map_t m);
        return {20'h0, m.mask, 1'b0, m.valid, m.base};
    endfunction

    // Only thermometer masks from the top bit down are accepted.
    function automatic logic mask_is_legal(input logic [MASK_W-1:0] m);
        logic ok;
        case (m)
            4'h8, 4'hC, 4'hE, 4'hF: ok = 1'b1;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Window size in bytes: low 24 bits all ones, cleared mask bits widen it.
    function automatic logic [SIZE_W-1:0] mask_to_size(input logic [MASK_W-1:0] m);
        logic [SIZE_W:0] s;
        s = {1'b0, ~m, 24'hFF_FFFF} + {{SIZE_W{1'b0}}, 1'b1};
        return s[SIZE_W-1:0];
    endfunction

    // Byte offset of the mapping register of chip select n.
    function automatic logic [11:0] map_offset(input int n);
        return 12'(MAP_FIRST + MAP_STRIDE * n);
    endfunction

endpackage

// File: rtl/cswd_map_bank.sv
// One chip select's mapping register with its legality check and window size.
// Assumes the write strobe is already decoded for this chip select; the stored
// value takes effect on the cycle after the write.
module cswd_map_bank
    import cswd_pkg::*;
#(
    parameter bit RST_VALID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [11:0]       wdata,
    output map_t              map_q,
    output logic              legal,
    output logic              active,
    output logic [SIZE_W-1:0] size
);

    localparam map_t RST_MAP = '{mask: 4'hF, valid: RST_VALID, base: '0};

    // Hold the mapping fields; a write replaces the whole window at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= RST_MAP;
        end else if (wr_en) begin
            map_q <= word_to_map(wdata);
        end
    end

    // Legal pair: accepted mask and no base bit under a cleared mask bit.
    // The 6-bit base field can never reach 0x40, so no range check is needed.
    always_comb begin
        legal = mask_is_legal(map_q.mask) &&
                ((map_q.base[MASK_W-1:0] & ~map_q.mask) == '0);
    end

    // The window decodes only when enabled and legal.
    always_comb begin
        active = map_q.valid && legal;
        size   = mask_to_size(map_q.mask);
    end

    // R6: a write lands as the exact stored window one cycle later
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_q == $past(word_to_map(wdata))));

    // R6: without a write the window never moves
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(map_q));

endmodule

// File: rtl/cswd_addr_match.sv
// Compares a bus address against every active window and picks the lowest
// matching chip select. Purely combinational; clk/rst_n feed only the checks.
// Assumes ADDR_W is greater than 30 so that an upper guard field exists.
module cswd_addr_match
    import cswd_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  map_t              maps   [NUM_CS],
    input  logic [NUM_CS-1:0] active,
    input  logic [SIZE_W-1:0] sizes  [NUM_CS],
    output logic [NUM_CS-1:0] sel,
    output logic [SIZE_W-1:0] hit_size
);

    localparam int FIELD_LO = 24;
    localparam int FIELD_HI = FIELD_LO + BASE_W - 1;

    logic              upper_zero;
    logic [NUM_CS-1:0] raw_hit;
    logic [FIELD_LO-1:0] unused_offset;

    // Addresses above the 1 GiB decode range never select.
    always_comb begin
        upper_zero    = (addr[ADDR_W-1:FIELD_HI+1] == '0);
        unused_offset = addr[FIELD_LO-1:0];
    end

    // Per chip select: compare the address field with the base under the mask.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        logic [BASE_W-1:0] care;
        always_comb begin
            care       = {2'b11, maps[g].mask};
            raw_hit[g] = active[g] && upper_zero &&
                         (((addr[FIELD_HI:FIELD_LO] ^ maps[g].base) & care) == '0);
        end
    end

    // Lowest-numbered match wins; the first hit found stops the search.
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (raw_hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Report the size of the selected window, zero without a match.
    always_comb begin
        hit_size = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel[i]) hit_size = hit_size | sizes[i];
        end
    end

    // R5: never more than one chip select
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5: a selection always reports a non-zero window size, none reports zero
    a_r5_size_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) == (hit_size == '0));

    // R4: nothing above the decode range is ever selected
    a_r4_upper_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:FIELD_HI+1] != '0) |-> (sel == '0));

endmodule

// File: rtl/cswd_irq_ctrl.sv
// Event status (set by sources, write-one-to-clear), event enable and the
// registered level interrupt. Assumes write strobes are already decoded.
module cswd_irq_ctrl
    import cswd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] stat_q,
    output logic [IRQ_W-1:0] en_q,
    output logic             irq_q
);

    logic [IRQ_W-1:0] clr_bits;

    // Bits cleared by a status write this cycle.
    always_comb begin
        clr_bits = clr_we ? wdata : '0;
    end

    // Status: sources set, ones written clear, a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_bits) | evt) & IRQ_KEEP;
        end
    end

    // Enable register keeps only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= wdata & IRQ_KEEP;
        end
    end

    // Interrupt level follows status AND enable one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_q & en_q);
        end
    end

    // R7: a written one with no event on that bit is gone next cycle
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat_q & $past(wdata & ~evt)) == '0));

    // R7: a source event is always captured when implemented
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & IRQ_KEEP) != '0 |=> ((stat_q & $past(evt & IRQ_KEEP)) == $past(evt & IRQ_KEEP)));

    // R9: with nothing enabled the interrupt is low next cycle
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_q);

endmodule

// File: rtl/cs_window_decoder.sv
// Top of the chip-select window decoder: register port decode, per-chip-select
// mapping banks, address matcher and interrupt logic.
// Assumes single-cycle register requests and word-aligned offsets; accesses
// to offsets that are not implemented read zero and writes to them are dropped.
module cs_window_decoder
    import cswd_pkg::*;
#(
    parameter int          NUM_CS   = 8,
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h0000_0051
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CS-1:0] cs_sel,
    output logic [SIZE_W-1:0] cs_hit_size,
    output logic [NUM_CS-1:0] map_err,
    input  logic [IRQ_W-1:0]  evt_in,
    output logic              irq
);

    logic              wr_any;
    logic              rd_any;
    logic [NUM_CS-1:0] map_wr;
    logic [NUM_CS-1:0] legal;
    logic [NUM_CS-1:0] active;
    map_t              maps  [NUM_CS];
    logic [SIZE_W-1:0] sizes [NUM_CS];
    logic [IRQ_W-1:0]  stat_q;
    logic [IRQ_W-1:0]  en_q;
    logic [31:0]       rd_val;
    logic [19:0]       unused_wdata_hi;

    // Qualify the register request by direction.
    always_comb begin
        wr_any          = reg_req && reg_we;
        rd_any          = reg_req && !reg_we;
        unused_wdata_hi = reg_wdata[31:12];
    end

    // One mapping bank per chip select; only chip select 0 boots enabled.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_comb begin
            map_wr[g]  = wr_any && (reg_addr == map_offset(g));
            map_err[g] = maps[g].valid && !legal[g];
        end

        cswd_map_bank #(
            .RST_VALID (g == 0)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (map_wr[g]),
            .wdata  (reg_wdata[11:0]),
            .map_q  (maps[g]),
            .legal  (legal[g]),
            .active (active[g]),
            .size   (sizes[g])
        );

        // R3: an illegal enabled mapping never drives its chip select
        a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            map_err[g] |-> !cs_sel[g]);
    end

    cswd_addr_match #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .maps     (maps),
        .active   (active),
        .sizes    (sizes),
        .sel      (cs_sel),
        .hit_size (cs_hit_size)
    );

    cswd_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_in),
        .clr_we (wr_any && (reg_addr == OFF_EVT_STAT)),
        .en_we  (wr_any && (reg_addr == OFF_EVT_EN)),
        .wdata  (reg_wdata[IRQ_W-1:0]),
        .stat_q (stat_q),
        .en_q   (en_q),
        .irq_q  (irq)
    );

    // Select the read value for the addressed offset; unknown offsets give 0.
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            OFF_ID:       rd_val = ID_VALUE;
            OFF_RSTDONE:  rd_val = 32'h1;
            OFF_EVT_STAT: rd_val = {{(32-IRQ_W){1'b0}}, stat_q};
            OFF_EVT_EN:   rd_val = {{(32-IRQ_W){1'b0}}, en_q};
            default: begin
                for (int i = 0; i < NUM_CS; i++) begin
                    if (reg_addr == map_offset(i)) rd_val = map_to_word(maps[i]);
                end
            end
        endcase
    end

    // Register the read data; it holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_any) begin
            reg_rdata <= rd_val;
        end
    end

    // R10: the reset-done register reads 1 whatever was written before
    a_r10_rstdone: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && reg_addr == OFF_RSTDONE) |=> (reg_rdata == 32'h1));

    // R11: read data does not move without a read request
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(reg_rdata));

    // R2: no mapping read ever shows bits outside the writable fields
    a_r2_map_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && reg_addr[11:4] >= 8'h07 && reg_addr <= map_offset(NUM_CS-1))
        |=> ((reg_rdata & ~32'h0000_0F7F) == '0));

endmodule

// File: tb/cs_window_decoder_test.sv
`timescale 1ns/1ps
module cs_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] bus_addr = '0;
    logic [7:0]  cs_sel;
    logic [27:0] cs_hit_size;
    logic [7:0]  map_err;
    logic [11:0] evt_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [31:0] m_map [8];
    logic [11:0] m_stat, m_en;
    logic        m_irq;
    logic [31:0] m_rdata;

    localparam logic [31:0] ID = 32'h0000_0051;

    cs_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_addr(bus_addr), .cs_sel(cs_sel), .cs_hit_size(cs_hit_size),
        .map_err(map_err), .evt_in(evt_in), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic bit ref_legal(input logic [31:0] w);
        int m;
        int b;
        m = int'(w[11:8]);
        b = int'(w[5:0]);
        if (!(m == 8 || m == 12 || m == 14 || m == 15)) return 1'b0;
        return ((b % 16) & (15 - m)) == 0;
    endfunction

    function automatic int ref_hit(input logic [31:0] a);
        for (int i = 0; i < 8; i++) begin
            int care;
            care = 48 + int'(m_map[i][11:8]);
            if (m_map[i][6] && ref_legal(m_map[i]) && a[31:30] == 2'b00 &&
                ((int'(a[29:24]) ^ int'(m_map[i][5:0])) & care) == 0)
                return i;
        end
        return -1;
    endfunction

    function automatic logic [27:0] ref_size(input logic [3:0] m);
        int z;
        z = 0;
        for (int k = 0; k < 4; k++) if (!m[k]) z++;
        return 28'(64'd1 << (24 + z));
    endfunction

    function automatic logic [31:0] ref_read(input logic [11:0] a);
        if (a == 12'h000) return ID;
        if (a == 12'h014) return 32'h1;
        if (a == 12'h018) return {20'h0, m_stat};
        if (a == 12'h01C) return {20'h0, m_en};
        for (int i = 0; i < 8; i++)
            if (int'(a) == 32'h78 + 32'h30 * i) return m_map[i];
        return 32'h0;
    endfunction

    // Reference model updated at each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_map[i] = (i == 0) ? 32'hF40 : 32'hF00;
            m_stat = '0; m_en = '0; m_irq = 1'b0; m_rdata = '0;
        end else begin
            logic [11:0] clr;
            m_irq = |(m_stat & m_en);
            clr = '0;
            if (reg_req && !reg_we) m_rdata = ref_read(reg_addr);
            if (reg_req && reg_we) begin
                if (reg_addr == 12'h018) clr = reg_wdata[11:0];
                if (reg_addr == 12'h01C) m_en = reg_wdata[11:0] & 12'hF03;
                for (int i = 0; i < 8; i++)
                    if (int'(reg_addr) == 32'h78 + 32'h30 * i)
                        m_map[i] = reg_wdata & 32'hF7F;
            end
            m_stat = ((m_stat & ~clr) | evt_in) & 12'hF03;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int h;
            h = ref_hit(bus_addr);
            chk("R5 cs_sel vs model", {24'h0, cs_sel}, h < 0 ? 32'h0 : (32'h1 << h));
            chk("R4 hit size vs model", {4'h0, cs_hit_size},
                h < 0 ? 32'h0 : {4'h0, ref_size(m_map[h][11:8])});
            for (int i = 0; i < 8; i++)
                chk("R3 map_err vs model", {31'h0, map_err[i]},
                    {31'h0, m_map[i][6] && !ref_legal(m_map[i])});
            chk("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            chk("R11 rdata vs model", reg_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        reg_req = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(posedge clk); #1; evt_in = v;
        @(posedge clk); #1; evt_in = '0;
    endtask

    task automatic look(input logic [31:0] a);
        @(posedge clk); #1; bus_addr = a; #1;
    endtask

    function automatic logic [11:0] moff(input int n);
        return 12'(32'h78 + 32'h30 * n);
    endfunction

    function automatic logic [31:0] mword(input int base, input int v, input int mask);
        return 32'(mask * 256 + v * 64 + base);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(moff(0), d); chk("R1 cs0 map reset", d, 32'hF40);
        rd(moff(3), d); chk("R1 cs3 map reset", d, 32'hF00);
        rd(12'h018, d); chk("R1 status reset", d, 0);
        rd(12'h01C, d); chk("R1 enable reset", d, 0);
        chk("R1 irq reset", {31'h0, irq}, 0);
        look(32'h0012_3456);
        chk("R1 boot window cs0", {24'h0, cs_sel}, 32'h01);
        chk("R4 boot size 16MiB", {4'h0, cs_hit_size}, 32'h0100_0000);

        // R10 fixed registers and unmapped offsets
        wr(12'h000, 32'hDEAD_BEEF); rd(12'h000, d); chk("R10 id ignores write", d, ID);
        wr(12'h014, 32'h0); rd(12'h014, d); chk("R10 reset-done reads 1", d, 1);
        rd(12'h040, d); chk("R10 unmapped reads 0", d, 0);
        rd(12'h079, d); chk("R10 misaligned reads 0", d, 0);

        // R2 writable bits only
        wr(moff(6), 32'hFFFF_FFFF); rd(moff(6), d); chk("R2 map mask", d, 32'hF7F);
        look(32'h3F00_0010); chk("R4 cs6 top window", {24'h0, cs_sel}, 32'h40);
        look(32'h7F00_0010); chk("R4 upper bits block", {24'h0, cs_sel}, 0);

        // R4 window sizes for each legal mask
        wr(moff(1), mword(8, 1, 8));
        look(32'h0A00_0000); chk("R4 mask 8 hit", {24'h0, cs_sel}, 32'h02);
        chk("R4 mask 8 size", {4'h0, cs_hit_size}, 32'h0800_0000);
        wr(moff(2), mword(4, 1, 12));
        look(32'h0700_0000); chk("R4 mask C hit", {24'h0, cs_sel}, 32'h04);
        chk("R4 mask C size", {4'h0, cs_hit_size}, 32'h0400_0000);
        wr(moff(7), mword(36, 1, 14));
        look(32'h2500_0000); chk("R4 mask E hit", {24'h0, cs_sel}, 32'h80);
        chk("R4 mask E size", {4'h0, cs_hit_size}, 32'h0200_0000);

        // R3 illegal mask and illegal base
        wr(moff(4), mword(16, 1, 10));
        look(32'h1000_0000); chk("R3 bad mask no select", {24'h0, cs_sel}, 0);
        chk("R3 bad mask flag", {24'h0, map_err}, 32'h10);
        wr(moff(5), mword(9, 1, 8));
        chk("R3 bad base flag", {24'h0, map_err}, 32'h30);
        wr(moff(5), mword(9, 0, 8));
        chk("R3 disabled clears flag", {24'h0, map_err}, 32'h10);

        // R5 priority on overlap
        wr(moff(3), mword(0, 1, 15));
        look(32'h0000_0100); chk("R5 lowest wins", {24'h0, cs_sel}, 32'h01);
        wr(moff(0), mword(0, 0, 15));
        look(32'h0000_0100); chk("R5 next in line", {24'h0, cs_sel}, 32'h08);
        look(32'h1800_0000); chk("R5 no match", {24'h0, cs_sel}, 0);

        // R6 remap takes effect next cycle
        look(32'h0400_0000);
        wr(moff(2), mword(16, 1, 15));
        chk("R6 old window gone", {24'h0, cs_sel}, 0);
        look(32'h1000_0000); chk("R6 new window live", {24'h0, cs_sel}, 32'h04);

        // R7 / R8 / R9 interrupts
        pulse(12'h001);
        rd(12'h018, d); chk("R7 event sets status", d, 32'h001);
        chk("R9 disabled stays low", {31'h0, irq}, 0);
        pulse(12'h0F0);
        rd(12'h018, d); chk("R7 unimplemented events ignored", d, 32'h001);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, d); chk("R8 enable mask", d, 32'hF03);
        chk("R9 irq raised", {31'h0, irq}, 1);
        wr(12'h018, 32'h001);
        @(posedge clk); #1;
        chk("R7 write-one clears", {31'h0, irq}, 0);
        @(posedge clk); #1;
        evt_in = 12'h200; reg_req = 1; reg_we = 1; reg_addr = 12'h018; reg_wdata = 32'h200;
        @(posedge clk); #1;
        evt_in = 0; reg_req = 0; reg_we = 0;
        rd(12'h018, d); chk("R7 set beats clear", d, 32'h200);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule